// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Slice

This block is a behavioural model of a small programmable logic slice. It holds four lookup tables, each 6 inputs wide and loaded as a 64-bit truth table through a parallel configuration port. Every table drives two outputs. The full output reads the whole table. The low output reads only the lower 32 entries, so one table can serve as two 5-input functions that share their address lines.

A fixed tree of three 2-to-1 multiplexers, steered by three external select pins, joins the tables. It builds a 7-input function from tables 0 and 1, another from tables 2 and 3, and one 8-input function from all four. Counting the four full outputs, the four low outputs, the two pair results and the top result, the slice offers eleven distinct results. Eight flip-flops can register any one of these results each. Each flip-flop has its own clock enable, and a configuration field chooses its source.

A common use is a 16-to-1 multiplexer. Each table is loaded as a 4-to-1 multiplexer, the two pair selects are tied to select bit 2, and the top select is driven from select bit 3.

Top module: `lut_slice`

## Requirements
- R1: A synchronous active-high reset clears all eight flip-flops and all four truth tables to zero, and sets every flip-flop source field to code 15. One clock edge after reset is asserted, `q` and `o6` read zero.
- R2: A clock edge with `cfg_we` high and `cfg_addr` in the range 0 to 3 loads `cfg_data` into that table, with bit n of the word answering address n. The other tables are left unchanged.
- R3: `o6[i]` equals bit `tbl_addr[6i+5:6i]` of table i, with no clock delay.
- R4: `o5[i]` equals bit `{0, tbl_addr[6i+4:6i]}` of table i, which is the lower half. With address bit 5 held at 1, `o6[i]` reads the upper half, so the table gives two independent 5-input functions. With address bit 5 at 0, `o5[i]` equals `o6[i]`.
- R5: `mx7[0]` is `o6[1]` when `mc[0]` is 1 and `o6[0]` otherwise. `mx7[1]` is `o6[3]` when `mc[1]` is 1 and `o6[2]` otherwise.
- R6: `mx8` is `mx7[1]` when `mc[2]` is 1 and `mx7[0]` otherwise.
- R7: A clock edge with `cfg_we` high and `cfg_addr` equal to 4 loads the source field of flip-flop k from `cfg_data[4k+3:4k]`. The source codes are: 0 to 3 for `o6[0..3]`, 4 to 7 for `o5[0..3]`, 8 and 9 for `mx7[0..1]`, 10 for `mx8`, and 11 to 15 for constant zero.
- R8: At a clock edge with `ff_en[k]` high, `q[k]` takes the value that its source code selected just before that edge.
- R9: At a clock edge with `ff_en[k]` low, `q[k]` keeps its value.
- R10: With each table loaded as a 4-to-1 multiplexer (data on address bits 3:0, select on bits 5:4), `mc[0]` and `mc[1]` tied to select bit 2, and `mc[2]` driven from select bit 3, `mx8` forms a 16-to-1 multiplexer.
- R11: A configuration write with `cfg_addr` from 5 to 7 changes no table and no source field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration target: tables 0-3, flip-flop sources at 4 |
| cfg_data | input | 64 | Configuration word |
| tbl_addr | input | 24 | Six address bits per table, table i at bits 6i+5:6i |
| mc | input | 3 | Wide-multiplexer selects: pair 0, pair 1, top |
| ff_en | input | 8 | Per-flip-flop clock enable |
| o6 | output | 4 | Full 6-input table outputs |
| o5 | output | 4 | Lower-half 5-input table outputs |
| mx7 | output | 2 | 7-input pair results |
| mx8 | output | 1 | 8-input result |
| q | output | 8 | Registered flip-flop outputs |

## Verification
A corrupted truth-table bit appears on `o6` or `o5` as soon as its address is presented, in the same cycle and with no clock involved. For that reason the bench sweeps every address of every table. A wrong flip-flop source field, or a write that lands on the wrong target, stays hidden until the next enabled edge, when the affected `q` bit takes the wrong result. The bench therefore sets each source code and compares `q` one edge later. A lost enable or a missing hold appears on `q` at the first edge where the enable is low.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;

    localparam int NUM_TBL    = 4;
    localparam int TBL_IN     = 6;
    localparam int TBL_BITS   = 1 << TBL_IN;
    localparam int HALF_BITS  = TBL_BITS / 2;
    localparam int NUM_PAIR   = NUM_TBL / 2;
    localparam int NUM_FF     = 8;
    localparam int SRC_W      = 4;
    localparam int CFG_ADDR_W = 3;
    localparam int CFG_FF_SEL = NUM_TBL;
    localparam int NUM_SRC    = 2 * NUM_TBL + NUM_PAIR + 1;

    typedef enum logic [SRC_W-1:0] {
        SRC_O6_0  = 4'd0,
        SRC_O6_1  = 4'd1,
        SRC_O6_2  = 4'd2,
        SRC_O6_3  = 4'd3,
        SRC_O5_0  = 4'd4,
        SRC_O5_1  = 4'd5,
        SRC_O5_2  = 4'd6,
        SRC_O5_3  = 4'd7,
        SRC_MX7_0 = 4'd8,
        SRC_MX7_1 = 4'd9,
        SRC_MX8   = 4'd10,
        SRC_ZERO  = 4'd15
    } ff_src_e;

    // Packing order puts each result at the bit that equals its source code.
    typedef struct packed {
        logic                mx8;
        logic [NUM_PAIR-1:0] mx7;
        logic [NUM_TBL-1:0]  o5;
        logic [NUM_TBL-1:0]  o6;
    } slice_comb_t;

    function automatic logic pick_source(logic [SRC_W-1:0] code, slice_comb_t c);
        logic [NUM_SRC-1:0] flat;
        logic               r;
        flat = c;
        r    = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int'(code) == s) r = flat[s];
        end
        return r;
    endfunction

endpackage

// File: rtl/lut_slice_table.sv
module lut_slice_table
    import lut_slice_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [TBL_BITS-1:0] wr_data,
    input  logic [TBL_IN-1:0]   addr,
    output logic                out_full,
    output logic                out_low
);
    logic [TBL_BITS-1:0]  truth;
    logic [HALF_BITS-1:0] low_half;

    always_ff @(posedge clk) begin
        if (rst)        truth <= '0;
        else if (wr_en) truth <= wr_data;
    end

    assign low_half = truth[HALF_BITS-1:0];
    assign out_full = truth[addr];
    assign out_low  = low_half[addr[TBL_IN-2:0]];
endmodule

// File: rtl/lut_slice_widemux.sv
module lut_slice_widemux
    import lut_slice_pkg::*;
(
    input  logic [NUM_TBL-1:0]  tbl_out,
    input  logic [NUM_PAIR:0]   sel,
    output logic [NUM_PAIR-1:0] pair_out,
    output logic                top_out
);
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pair_out[p] = sel[p] ? tbl_out[2*p+1] : tbl_out[2*p];
    end

    // Two pairs feed the top stage.
    assign top_out = sel[NUM_PAIR] ? pair_out[1] : pair_out[0];
endmodule

// File: rtl/lut_slice_ffbank.sv
module lut_slice_ffbank
    import lut_slice_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [NUM_FF*SRC_W-1:0] cfg_word,
    input  slice_comb_t             comb,
    input  logic [NUM_FF-1:0]       en,
    output logic [NUM_FF-1:0]       q
);
    logic [SRC_W-1:0] src_sel [NUM_FF];

    for (genvar k = 0; k < NUM_FF; k++) begin : g_ff
        logic d_next;

        always_ff @(posedge clk) begin
            if (rst)         src_sel[k] <= SRC_ZERO;
            else if (cfg_wr) src_sel[k] <= cfg_word[k*SRC_W +: SRC_W];
        end

        assign d_next = pick_source(src_sel[k], comb);

        always_ff @(posedge clk) begin
            if (rst)        q[k] <= 1'b0;
            else if (en[k]) q[k] <= d_next;
        end
    end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lut_slice_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [CFG_ADDR_W-1:0]     cfg_addr,
    input  logic [TBL_BITS-1:0]       cfg_data,
    input  logic [NUM_TBL*TBL_IN-1:0] tbl_addr,
    input  logic [NUM_PAIR:0]         mc,
    input  logic [NUM_FF-1:0]         ff_en,
    output logic [NUM_TBL-1:0]        o6,
    output logic [NUM_TBL-1:0]        o5,
    output logic [NUM_PAIR-1:0]       mx7,
    output logic                      mx8,
    output logic [NUM_FF-1:0]         q
);
    slice_comb_t comb;
    logic        ff_cfg_wr;

    for (genvar i = 0; i < NUM_TBL; i++) begin : g_tbl
        logic tbl_wr;
        assign tbl_wr = cfg_we && (int'(cfg_addr) == i);

        lut_slice_table u_table (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (tbl_wr),
            .wr_data  (cfg_data),
            .addr     (tbl_addr[i*TBL_IN +: TBL_IN]),
            .out_full (o6[i]),
            .out_low  (o5[i])
        );
    end

    lut_slice_widemux u_widemux (
        .tbl_out  (o6),
        .sel      (mc),
        .pair_out (mx7),
        .top_out  (mx8)
    );

    assign comb.o6  = o6;
    assign comb.o5  = o5;
    assign comb.mx7 = mx7;
    assign comb.mx8 = mx8;

    assign ff_cfg_wr = cfg_we && (int'(cfg_addr) == CFG_FF_SEL);

    lut_slice_ffbank u_ffbank (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (ff_cfg_wr),
        .cfg_word (cfg_data[NUM_FF*SRC_W-1:0]),
        .comb     (comb),
        .en       (ff_en),
        .q        (q)
    );
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
    import lut_slice_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_TBL*TBL_IN-1:0] tbl_addr,
    input logic [NUM_PAIR:0]         mc,
    input logic [NUM_FF-1:0]         ff_en,
    input logic [NUM_TBL-1:0]        o6,
    input logic [NUM_TBL-1:0]        o5,
    input logic [NUM_PAIR-1:0]       mx7,
    input logic                      mx8,
    input logic [NUM_FF-1:0]         q
);
    AST_Q_RESET: assert property (@(posedge clk) rst |=> (q == '0)); // R1

    for (genvar k = 0; k < NUM_FF; k++) begin : g_hold
        AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
            !ff_en[k] |=> (q[k] == $past(q[k]))); // R9
    end

    for (genvar i = 0; i < NUM_TBL; i++) begin : g_half
        AST_LOWHALF_AGREE: assert property (@(posedge clk) disable iff (rst)
            !tbl_addr[i*TBL_IN + TBL_IN - 1] |-> (o5[i] == o6[i])); // R4
    end

    AST_MX7_PAIR: assert property (@(posedge clk) disable iff (rst)
        !mc[1] |-> (mx7[1] == o6[2])); // R5

    AST_MX8_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!mc[2] && !mc[0]) |-> (mx8 == o6[0])); // R6

    AST_MX8_LAST: assert property (@(posedge clk) disable iff (rst)
        (mc[2] && mc[1]) |-> (mx8 == o6[3])); // R6
endmodule

bind lut_slice lut_slice_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tbl_addr (tbl_addr),
    .mc       (mc),
    .ff_en    (ff_en),
    .o6       (o6),
    .o5       (o5),
    .mx7      (mx7),
    .mx8      (mx8),
    .q        (q)
);

// File: tb/lut_slice_tb.sv
module lut_slice_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [63:0] cfg_data = '0;
    logic [23:0] tbl_addr = '0;
    logic [2:0]  mc = '0;
    logic [7:0]  ff_en = '0;
    logic [3:0]  o6, o5;
    logic [1:0]  mx7;
    logic        mx8;
    logic [7:0]  q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [63:0] TT_VEC [0:3] = '{
        64'hA5C3_0F96_3C71_E2D8,
        64'h1234_5678_9ABC_DEF0,
        64'hF0E1_D2C3_B4A5_9687,
        64'h6B2D_83F4_05CE_71A9
    };
    localparam logic [15:0] MUX_VEC [0:4] = '{
        16'h0001, 16'h8000, 16'hA5A5, 16'h3C96, 16'hFFFE
    };

    logic [63:0] tt [4];

    always #4 clk = ~clk;

    lut_slice u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .tbl_addr(tbl_addr), .mc(mc), .ff_en(ff_en),
        .o6(o6), .o5(o5), .mx7(mx7), .mx8(mx8), .q(q)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] a, logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected results, bit position equals source code.
    function automatic logic [10:0] model(logic [23:0] ad, logic [2:0] m);
        logic [3:0] e6, e5;
        logic a0, a1, top;
        for (int i = 0; i < 4; i++) begin
            e6[i] = tt[i][ad[6*i +: 6]];
            e5[i] = tt[i][{1'b0, ad[6*i +: 5]}];
        end
        a0  = m[0] ? e6[1] : e6[0];
        a1  = m[1] ? e6[3] : e6[2];
        top = m[2] ? a1 : a0;
        return {top, a1, a0, e5, e6};
    endfunction

    function automatic logic [7:0] exp_q(logic [31:0] codes, logic [10:0] res);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) begin
            int c = int'(codes[4*k +: 4]);
            r[k] = (c < 11) ? res[c] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [63:0] mux4_table();
        logic [63:0] t;
        for (int a = 0; a < 64; a++) begin
            logic [5:0] av = 6'(a);
            t[a] = av[av[5:4]];
        end
        return t;
    endfunction

    task automatic capture(string req, logic [31:0] codes, logic [23:0] ad, logic [2:0] m);
        logic [7:0] e;
        @(negedge clk);
        tbl_addr = ad; mc = m; ff_en = 8'hFF;
        e = exp_q(codes, model(ad, m));
        @(negedge clk);
        ff_en = 8'h00;
        check(req, 32'(q), 32'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] qsave;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 q", 32'(q), 32'h0);
        check("R1 o6", 32'(o6), 32'h0);

        // R2: load each table
        for (int i = 0; i < 4; i++) begin
            tt[i] = TT_VEC[i];
            cfg_write(3'(i), TT_VEC[i]);
        end

        // R3, R4: exhaustive lookup, shared addresses
        for (int a = 0; a < 64; a++) begin
            logic [10:0] r;
            tbl_addr = {4{6'(a)}};
            #1;
            r = model(tbl_addr, mc);
            check("R3 o6", 32'(o6), 32'(r[3:0]));
            check("R4 o5", 32'(o5), 32'(r[7:4]));
        end

        // R5, R6: every select pattern, distinct addresses per table
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 64; a++) begin
                logic [10:0] r;
                logic [5:0] av = 6'(a);
                tbl_addr = {av ^ 6'd39, av ^ 6'd26, av ^ 6'd13, av};
                mc = 3'(m);
                #1;
                r = model(tbl_addr, mc);
                check("R5 mx7", 32'(mx7), 32'(r[9:8]));
                check("R6 mx8", 32'(mx8), 32'(r[10]));
            end
        end

        // R2: overwrite table 1 only
        tt[1] = ~TT_VEC[1];
        cfg_write(3'd1, ~TT_VEC[1]);
        for (int a = 0; a < 64; a += 7) begin
            logic [10:0] r;
            tbl_addr = {4{6'(a)}};
            #1;
            r = model(tbl_addr, mc);
            check("R2 o6 after single write", 32'(o6), 32'(r[3:0]));
        end

        // R7, R8: source codes 0..7 then 8..15 mix
        cfg_write(3'd4, 64'(32'h7654_3210));
        capture("R8 codes 0-7", 32'h7654_3210, 24'h5A3C71, 3'b000);
        capture("R8 codes 0-7", 32'h7654_3210, 24'hC3A59E, 3'b111);
        cfg_write(3'd4, 64'(32'hFEBA_9834));
        for (int m = 0; m < 8; m++)
            capture("R7 codes 8-15", 32'hFEBA_9834, 24'h3F0A17 ^ 24'(m * 24'h10413), 3'(m));

        // R9: hold with enables low
        @(negedge clk);
        qsave = q;
        ff_en = 8'h00; tbl_addr = ~tbl_addr; mc = ~mc;
        @(negedge clk);
        check("R9 hold", 32'(q), 32'(qsave));
        // partial enable: only bit 0 may change
        ff_en = 8'h01;
        @(negedge clk);
        ff_en = 8'h00;
        check("R9 partial hold", 32'(q[7:1]), 32'(qsave[7:1]));

        // R11: writes to unused addresses
        cfg_write(3'd5, '1);
        cfg_write(3'd6, '0);
        cfg_write(3'd7, '1);
        for (int a = 0; a < 64; a += 5) begin
            logic [10:0] r;
            tbl_addr = {4{6'(a)}};
            #1;
            r = model(tbl_addr, mc);
            check("R11 tables intact", 32'({o5, o6}), 32'(r[7:0]));
        end
        capture("R11 sources intact", 32'hFEBA_9834, 24'h91C2E4, 3'b101);

        // R10: 16-to-1 multiplexer
        for (int i = 0; i < 4; i++) begin
            tt[i] = mux4_table();
            cfg_write(3'(i), tt[i]);
        end
        for (int v = 0; v < 5; v++) begin
            for (int s = 0; s < 16; s++) begin
                logic [15:0] d = MUX_VEC[v];
                logic [3:0]  sv = 4'(s);
                for (int i = 0; i < 4; i++)
                    tbl_addr[6*i +: 6] = {sv[1:0], d[4*i +: 4]};
                mc = {sv[3], sv[2], sv[2]};
                #1;
                check("R10 mux16", 32'(mx8), 32'(d[sv]));
            end
        end

        // R1: reset after activity
        capture("R8 before reset", 32'hFEBA_9834, 24'h0F0F0F, 3'b010);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 q cleared", 32'(q), 32'h0);
        tbl_addr = 24'hFFFFFF;
        #1;
        check("R1 tables cleared", 32'({o5, o6}), 32'h0);
        for (int i = 0; i < 4; i++) tt[i] = '0;
        capture("R1 sources zero code", 32'hFFFF_FFFF, 24'hFFFFFF, 3'b111);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule